// File: doc/BRIEF.md
# TDM Serial Output Serializer with Programmable Advancement

The block converts channel bytes, fetched one at a time from an upstream source, into a single serial time-division multiplexed output stream. A frame spans 8192 ticks of a fixed oversampling clock (65.536 MHz nominal, so 125 us). It carries 32, 64, 128 or 256 eight-bit channels, depending on the selected line rate of 2.048, 4.096, 8.192 or 16.384 Mbps. A one-tick frame pulse keeps an internal frame timer aligned. Without pulses, the timer wraps by itself.

The output can be moved earlier than its frame-aligned position, which makes up for the delay of the wire and the receiver downstream. The shift is a whole number of bit periods (0 to 7) plus a fraction of a bit. The block works out the shifted stream position, asks upstream for each byte one byte time before that byte goes out, and shifts the byte out MSB first. Rate and advancement settings are taken only at a frame boundary.

Top module: `tdm_adv_ser`

## Requirements
- R1: While `rst_ni` is low, `ser_o` is 1 and `req_o` is 0.
- R2: Rate code `rate_i` 0/1/2/3 selects 2.048/4.096/8.192/16.384 Mbps, which is 32/16/8/4 ticks per bit and 32/64/128/256 channels. Channels go out in ascending order from 0, each byte MSB first.
- R3: With zero advancement, bit 7 of channel 0 is on `ser_o` in tick 0. Tick 0 is the cycle after the one in which `frame_i` is high.
- R4: `adv_bits_i` (0 to 7) moves the whole output earlier by that many bit periods.
- R5: At rate codes 0 to 2, `adv_frac_i` moves the output a further `adv_frac_i` quarter bits earlier.
- R6: At rate code 3, bit 0 of `adv_frac_i` is ignored, so the fraction is 0 or 1/2 bit.
- R7: `req_o` is a one-cycle pulse in the first tick of each advanced channel slot, and also in tick 0. `req_chan_o` then names the channel that follows the current slot, modulo the channel count, and holds that value between pulses. `byte_i` is sampled at the clock edge that starts that channel's slot.
- R8: With non-zero advancement, channel 0 of the next frame follows the last channel with no gap and starts before the frame pulse.
- R9: A change of `rate_i`, `adv_bits_i` or `adv_frac_i` takes effect only from tick 0 of the next frame.
- R10: A `frame_i` pulse in any tick restarts the frame at tick 0 in the next cycle. Without a pulse, the timer wraps from 8191 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame pulse; the next cycle is tick 0 |
| rate_i | input | 2 | Line rate code |
| adv_bits_i | input | 3 | Whole-bit advancement |
| adv_frac_i | input | 2 | Fractional advancement in quarter bits |
| byte_i | input | 8 | Requested channel byte from upstream |
| ser_o | output | 1 | Serial output stream |
| req_o | output | 1 | Byte request pulse |
| req_chan_o | output | 8 | Channel number being requested |

## Verification
A wrong frame timer or a wrong advancement sum shows on `ser_o` as a shift of whole bit cells or quarter-bit cells. It also moves the `req_o` pulses off their slot starts within one channel time (32 to 256 ticks), so the bench compares every tick against a position computed from the settings. A wrong request channel or a stale shift register brings a wrong byte pattern into the very next slot. A setting latched in the wrong cycle shows in the rest of the frame where the change was made, because the old timing must still hold there.

// File: rtl/tdm_adv_pkg.sv
package tdm_adv_pkg;
  localparam int RATE_W   = 2;
  localparam int WHOLE_W  = 3;
  localparam int FRAC_W   = 2;
  localparam int NUM_RATES = 1 << RATE_W;

  typedef struct packed {
    logic [RATE_W-1:0]  rate;
    logic [WHOLE_W-1:0] whole;
    logic [FRAC_W-1:0]  frac;
  } adv_cfg_t;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_adv_pkg::*;
#(
  parameter int FRAME_LOG2 = 13
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_i,
  input  adv_cfg_t              cfg_i,
  output logic [FRAME_LOG2-1:0] tick_q_o,
  output logic [FRAME_LOG2-1:0] tick_nxt_o,
  output logic                  load_o,
  output adv_cfg_t              cfg_q_o,
  output adv_cfg_t              cfg_nxt_o
);
  logic [FRAME_LOG2-1:0] tick_q;
  adv_cfg_t              cfg_q;

  assign tick_nxt_o = frame_i ? '0 : tick_q + FRAME_LOG2'(1);
  assign load_o     = (tick_nxt_o == '0);
  // settings only move at a frame boundary
  assign cfg_nxt_o  = load_o ? cfg_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '1;
      cfg_q  <= '0;
    end else begin
      tick_q <= tick_nxt_o;
      cfg_q  <= cfg_nxt_o;
    end
  end

  assign tick_q_o = tick_q;
  assign cfg_q_o  = cfg_q;
endmodule

// File: rtl/tdm_adv_calc.sv
module tdm_adv_calc
  import tdm_adv_pkg::*;
#(
  parameter int FRAME_LOG2   = 13,
  parameter int MIN_TPB_LOG2 = 2,
  parameter int CHAN_W       = FRAME_LOG2 - MIN_TPB_LOG2 - 3
) (
  input  logic [FRAME_LOG2-1:0] tick_i,
  input  adv_cfg_t              cfg_i,
  output logic [FRAME_LOG2-1:0] adv_o,
  output logic                  bit_start_o,
  output logic                  chan_start_o,
  output logic [CHAN_W-1:0]     next_chan_o
);
  logic [FRAME_LOG2-1:0] adv_r   [NUM_RATES];
  logic [FRAME_LOG2-1:0] pos_r   [NUM_RATES];
  logic                  bit0_r  [NUM_RATES];
  logic                  byte0_r [NUM_RATES];
  logic [CHAN_W-1:0]     chan_r  [NUM_RATES];
  logic [CHAN_W-1:0]     next_r  [NUM_RATES];

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
    localparam int TL = MIN_TPB_LOG2 + NUM_RATES - 1 - r;
    localparam int BL = TL + 3;
    localparam logic [CHAN_W-1:0] NMASK = CHAN_W'((1 << (FRAME_LOG2 - BL)) - 1);
    logic [FRAC_W-1:0] frac_eff;

    // fastest rate only has half-bit steps
    assign frac_eff    = (r == NUM_RATES - 1) ? {cfg_i.frac[1], 1'b0} : cfg_i.frac;
    assign adv_r[r]    = (FRAME_LOG2'(cfg_i.whole) << TL)
                       + ((FRAME_LOG2'(frac_eff) << TL) >> 2);
    assign pos_r[r]    = tick_i + adv_r[r];
    assign bit0_r[r]   = (pos_r[r][TL-1:0] == '0);
    assign byte0_r[r]  = (pos_r[r][BL-1:0] == '0);
    assign chan_r[r]   = CHAN_W'(pos_r[r] >> BL);
    assign next_r[r]   = (chan_r[r] + CHAN_W'(1)) & NMASK;
  end

  assign adv_o        = adv_r[cfg_i.rate];
  assign bit_start_o  = bit0_r[cfg_i.rate];
  assign chan_start_o = byte0_r[cfg_i.rate];
  assign next_chan_o  = next_r[cfg_i.rate];
endmodule

// File: rtl/tdm_shift_out.sv
module tdm_shift_out #(
  parameter int CHAN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_start_i,
  input  logic              chan_start_i,
  input  logic              load_i,
  input  logic [CHAN_W-1:0] next_chan_i,
  input  logic [7:0]        byte_i,
  output logic              ser_o,
  output logic              req_o,
  output logic [CHAN_W-1:0] req_chan_o
);
  logic [7:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      ser_o  <= 1'b1;
    end else if (chan_start_i) begin
      ser_o  <= byte_i[7];
      sreg_q <= {byte_i[6:0], 1'b0};
    end else if (bit_start_i) begin
      ser_o  <= sreg_q[7];
      sreg_q <= {sreg_q[6:0], 1'b0};
    end
  end

  // extra request at tick 0 refills after a timing jump
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o      <= 1'b0;
      req_chan_o <= '0;
    end else begin
      req_o <= chan_start_i | load_i;
      if (chan_start_i | load_i) req_chan_o <= next_chan_i;
    end
  end
endmodule

// File: rtl/tdm_adv_ser.sv
module tdm_adv_ser
  import tdm_adv_pkg::*;
#(
  parameter int FRAME_LOG2   = 13,
  parameter int MIN_TPB_LOG2 = 2,
  parameter int CHAN_W       = FRAME_LOG2 - MIN_TPB_LOG2 - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [1:0]        rate_i,
  input  logic [2:0]        adv_bits_i,
  input  logic [1:0]        adv_frac_i,
  input  logic [7:0]        byte_i,
  output logic              ser_o,
  output logic              req_o,
  output logic [CHAN_W-1:0] req_chan_o
);
  adv_cfg_t              cfg_in;
  adv_cfg_t              cfg_q;
  adv_cfg_t              cfg_nxt;
  logic [FRAME_LOG2-1:0] tick_q;
  logic [FRAME_LOG2-1:0] tick_nxt;
  logic [FRAME_LOG2-1:0] adv_ticks;
  logic                  load;
  logic                  bit_start;
  logic                  chan_start;
  logic [CHAN_W-1:0]     next_chan;

  assign cfg_in = '{rate: rate_i, whole: adv_bits_i, frac: adv_frac_i};

  tdm_frame_timer #(.FRAME_LOG2(FRAME_LOG2)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .cfg_i      (cfg_in),
    .tick_q_o   (tick_q),
    .tick_nxt_o (tick_nxt),
    .load_o     (load),
    .cfg_q_o    (cfg_q),
    .cfg_nxt_o  (cfg_nxt)
  );

  // evaluated for the tick being entered so outputs are registered
  tdm_adv_calc #(
    .FRAME_LOG2  (FRAME_LOG2),
    .MIN_TPB_LOG2(MIN_TPB_LOG2),
    .CHAN_W      (CHAN_W)
  ) u_calc (
    .tick_i      (tick_nxt),
    .cfg_i       (cfg_nxt),
    .adv_o       (adv_ticks),
    .bit_start_o (bit_start),
    .chan_start_o(chan_start),
    .next_chan_o (next_chan)
  );

  tdm_shift_out #(.CHAN_W(CHAN_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_start_i (bit_start),
    .chan_start_i(chan_start),
    .load_i      (load),
    .next_chan_i (next_chan),
    .byte_i      (byte_i),
    .ser_o       (ser_o),
    .req_o       (req_o),
    .req_chan_o  (req_chan_o)
  );
endmodule

// File: rtl/tdm_adv_ser_chk.sv
module tdm_adv_ser_chk
  import tdm_adv_pkg::*;
#(
  parameter int FRAME_LOG2 = 13,
  parameter int CHAN_W     = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  frame_i,
  input logic                  req_o,
  input logic [CHAN_W-1:0]     req_chan_o,
  input logic [FRAME_LOG2-1:0] tick_q,
  input adv_cfg_t              cfg_q,
  input adv_cfg_t              cfg_nxt,
  input logic [FRAME_LOG2-1:0] adv_ticks
);
  // R7
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  // R7
  req_chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> $stable(req_chan_o));

  // R10
  frame_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (tick_q == '0));

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q != '0) |-> $stable(cfg_q));

  // R6
  half_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_nxt.rate == 2'd3) |-> (adv_ticks[0] == 1'b0));
endmodule

bind tdm_adv_ser tdm_adv_ser_chk #(
  .FRAME_LOG2(FRAME_LOG2),
  .CHAN_W    (CHAN_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_i   (frame_i),
  .req_o     (req_o),
  .req_chan_o(req_chan_o),
  .tick_q    (tick_q),
  .cfg_q     (cfg_q),
  .cfg_nxt   (cfg_nxt),
  .adv_ticks (adv_ticks)
);

// File: tb/tdm_adv_ser_tb.sv
`timescale 1ns/1ps
module tdm_adv_ser_tb;
  localparam int FRAME  = 8192;
  localparam int CW     = 8;
  localparam int SKIP_T = 1024;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          frame_i;
  logic [1:0]    rate_i;
  logic [2:0]    adv_bits_i;
  logic [1:0]    adv_frac_i;
  logic [7:0]    byte_i;
  logic          ser_o;
  logic          req_o;
  logic [CW-1:0] req_chan_o;

  always #2.5 clk = ~clk;

  tdm_adv_ser u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .rate_i(rate_i),
    .adv_bits_i(adv_bits_i), .adv_frac_i(adv_frac_i), .byte_i(byte_i),
    .ser_o(ser_o), .req_o(req_o), .req_chan_o(req_chan_o)
  );

  int checks = 0;
  int errors = 0;
  int t_b;
  int in_rate = 0, in_whole = 0, in_frac = 0;
  int a_rate = 0, a_whole = 0, a_frac = 0;
  bit skip = 1'b1, disc = 1'b0, old_region = 1'b0;
  bit early_arm = 1'b0, after_early = 1'b0, no_fp = 1'b0;
  int early_at = 0;

  function automatic logic [7:0] data_f(int c);
    return 8'((c * 73 + 90) ^ (c >> 3));
  endfunction

  function automatic int adv_f(int rate, int whole, int frac);
    int tl = 5 - rate;
    int f  = (rate == 3) ? (frac & 2) : frac;
    return (whole << tl) + ((f << tl) >> 2);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t_b, act, exp);
    end
  endtask

  task automatic check_outputs();
    int tl  = 5 - a_rate;
    int bt  = 1 << (tl + 3);
    int nch = FRAME / bt;
    int adv = adv_f(a_rate, a_whole, a_frac);
    int p   = (t_b + adv) % FRAME;
    int ch  = p / bt;
    int bn  = 7 - ((p % bt) >> tl);
    logic [7:0] d;
    bit exp_ser, exp_req;
    string tag;
    d = data_f(ch);
    exp_ser = d[bn];
    if (old_region)                       tag = "R9";
    else if (after_early || no_fp)        tag = "R10";
    else if (t_b + adv >= FRAME)          tag = "R8";
    else if (a_rate == 3 && a_frac != 0)  tag = "R6";
    else if (a_frac != 0)                 tag = "R5";
    else if (a_whole != 0)                tag = "R4";
    else if (t_b < bt)                    tag = "R3";
    else                                  tag = "R2";
    chk(ser_o == exp_ser, tag, int'(ser_o), int'(exp_ser));
    exp_req = ((p % bt) == 0) || (t_b == 0);
    chk(req_o == exp_req, "R7 req", int'(req_o), int'(exp_req));
    if (exp_req && req_o)
      chk(int'(req_chan_o) == (ch + 1) % nch, "R7 chan", int'(req_chan_o), (ch + 1) % nch);
  endtask

  task automatic cycle();
    bit fp, fired;
    int t_n;
    fired = early_arm && (t_b == early_at);
    fp = (!no_fp && t_b == FRAME - 1) || fired;
    if (fired) begin early_arm = 1'b0; disc = 1'b1; end
    frame_i = fp;
    t_n = fp ? 0 : (t_b + 1) % FRAME;
    if (t_n == 0) begin
      if (disc || in_rate != a_rate || in_whole != a_whole || in_frac != a_frac) skip = 1'b1;
      after_early = fired;
      old_region = 1'b0;
      disc = 1'b0;
      a_rate = in_rate; a_whole = in_whole; a_frac = in_frac;
    end
    @(negedge clk);
    t_b = t_n;
    if (skip && t_b >= SKIP_T) skip = 1'b0;
    if (!skip) check_outputs();
    if (req_o) byte_i = data_f(int'(req_chan_o));
  endtask

  task automatic run_until(int tt);
    do cycle(); while (t_b != tt);
  endtask

  task automatic seg(int r, int w, int f);
    in_rate = r; in_whole = w; in_frac = f;
    rate_i = 2'(r); adv_bits_i = 3'(w); adv_frac_i = 2'(f);
    old_region = (r != a_rate) || (w != a_whole) || (f != a_frac);
    cycle();
    run_until(3000);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; frame_i = 1'b0; byte_i = 8'h00;
    rate_i = '0; adv_bits_i = '0; adv_frac_i = '0;
    repeat (8) @(negedge clk);
    chk(ser_o == 1'b1, "R1 ser", int'(ser_o), 1);
    chk(req_o == 1'b0, "R1 req", int'(req_o), 0);
    rst_ni = 1'b1;
    t_b = FRAME - 1;
    run_until(3000);
    seg(0, 0, 0);
    seg(3, 0, 0);
    seg(1, 7, 3);
    seg(3, 5, 3);
    seg(2, 3, 1);
    seg(0, 1, 2);
    for (int i = 0; i < 3; i++)
      seg(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 3)));
    early_at = 5000; early_arm = 1'b1;
    seg(1, 2, 1);
    no_fp = 1'b1;
    seg(1, 2, 1);
    no_fp = 1'b0;
    seg(3, 7, 2);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule